// File: doc/BRIEF.md
# Block Cipher Mode Sequencer

This block is the command and chaining controller that sits in front of a 128-bit block-cipher engine. Software or a DMA channel talks to it through byte-wide ports: a command write carries a command code and a mode code, an input byte port accepts data, and an output byte port delivers results. The block fills the key register or the chaining (IV/nonce) register, or collects the data of one block. It hands a prepared 128-bit word to the engine over a start/done handshake and applies the selected chaining mode to the engine's answer. It then presents the result one byte at a time, most significant byte first.

Every block needs its own start command. Block modes (ECB, CBC, CBC-MAC) move 16 bytes in and 16 bytes out per start. Feedback modes (CFB, OFB, CTR) run the engine once per block but move the data as four 4-byte segments: each segment is written in and its result read out before the next segment is asked for. One-cycle request strobes tell a DMA channel when a byte is wanted or available. A one-cycle interrupt marks the end of each block's readout. A key or IV command abandons whatever block is in flight. A final short block must be zero-padded by the caller before it is written.

Top module: `bcs_top`

## Requirements
- R1: After reset the key (`eng_key`) and chaining register are zero, `ready` is 1, and `in_req`, `out_req`, `irq` and `eng_start` are 0.
- R2: Command code 1 (key load) makes the next 16 accepted input bytes, first byte most significant, the key shown on `eng_key`; the key changes at no other time.
- R3: Mode code 0 (ECB): a block's result is the engine output for the 16 collected bytes.
- R4: Mode code 1 (CBC): the engine input is the data XOR the chaining register, and the result becomes the new chaining value; command code 2 (IV load) fills the chaining register with 16 bytes and captures the mode field.
- R5: Mode code 2 (CFB): the engine encrypts the chaining register once per block, each 32-bit data segment is XORed with the matching keystream word (most significant word first), and the 128-bit ciphertext becomes the next chaining value.
- R6: Mode code 3 (OFB): as R5 for the data, but the keystream itself becomes the next chaining value.
- R7: Mode code 4 (CTR): as R5 for the data, then the low 32 bits of the chaining register increase by one modulo 2^32 with no carry into bit 32.
- R8: Mode code 5 (CBC-MAC) chains like CBC; command code 3 (start) also captures the mode field without touching the chaining register, so the mode may change for the last block.
- R9: A start command while `ready` is 0 is ignored, and input bytes written when no load or collection is open are ignored.
- R10: A key or IV command in any state abandons the block in progress without an interrupt; if it coincides with an input byte write, the byte is dropped.
- R11: `irq` pulses for one cycle when the last result byte of a block is read, in the same cycle `ready` returns to 1.
- R12: `in_req` pulses once for each input byte wanted and `out_req` once for each result byte available: 16 of each per block in every mode, never both at once.
- R13: `eng_start` is a one-cycle pulse, issued once per block in every mode, and `eng_din` holds steady while the result is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 2 | 0 none, 1 key load, 2 IV load, 3 start block |
| cmd_mode | input | 3 | Mode code, captured by IV load and start |
| ready | output | 1 | High when no block is pending |
| din_we | input | 1 | Input byte write strobe |
| din | input | 8 | Input byte |
| in_req | output | 1 | One-cycle request for the next input byte |
| dout_re | input | 1 | Output byte read strobe |
| dout | output | 8 | Current result byte |
| out_req | output | 1 | One-cycle notice that a result byte is available |
| irq | output | 1 | One-cycle block completion pulse |
| eng_start | output | 1 | Engine start pulse |
| eng_din | output | 128 | Engine input word |
| eng_key | output | 128 | Key for the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_dout | input | 128 | Engine result word |

## Verification
A command write and an input byte write can land in the same cycle. The bench issues an IV load together with a data byte in the middle of a block's collection. Priority is judged by the next chaining result: if the byte had been taken as the first IV byte, the following CBC block would mismatch the bench model. A start issued while a block is still collecting is also provoked, and is judged by unchanged results and unchanged request counts.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_KEY  = 2'd1;
  localparam logic [1:0] CMD_IV   = 2'd2;
  localparam logic [1:0] CMD_GO   = 2'd3;

  localparam logic [2:0] MD_ECB = 3'd0;
  localparam logic [2:0] MD_CBC = 3'd1;
  localparam logic [2:0] MD_CFB = 3'd2;
  localparam logic [2:0] MD_OFB = 3'd3;
  localparam logic [2:0] MD_CTR = 3'd4;
  localparam logic [2:0] MD_MAC = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LKEY, ST_LIV, ST_FILL, ST_RUN, ST_EMIT
  } seq_st_e;

  function automatic logic is_stream(input logic [2:0] m);
    return (m == MD_CFB) || (m == MD_OFB) || (m == MD_CTR);
  endfunction
endpackage

// File: rtl/bcs_shift8.sv
`timescale 1ns/1ps
module bcs_shift8 #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         sh,
  input  logic [7:0]   sh_in,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ld)      q_d = ld_val;
    else if (sh) q_d = {q[W-9:0], sh_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (ld || sh)  q <= q_d;
  end
endmodule

// File: rtl/bcs_mode_path.sv
`timescale 1ns/1ps
module bcs_mode_path
  import bcs_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int SEG_W = 32,
  parameter int CTR_W = 32,
  parameter int NSEG  = BLK_W / SEG_W,
  parameter int SIW   = $clog2(NSEG)
) (
  input  logic [2:0]             mode,
  input  logic [BLK_W-1:0]       in_blk,
  input  logic [BLK_W-1:0]       chain,
  input  logic [BLK_W-1:0]       ks_reg,
  input  logic [BLK_W-1:0]       eng_dout,
  input  logic [SIW-1:0]         seg,
  input  logic [BLK_W-SEG_W-1:0] ct_prev,
  output logic [BLK_W-1:0]       eng_din,
  output logic [SEG_W-1:0]       seg_res,
  output logic [BLK_W-1:0]       fb_next
);
  logic [BLK_W-1:0] ks_now;
  logic [SEG_W-1:0] ks_words [NSEG];

  // first segment uses the fresh engine answer, later ones the stored keystream
  assign ks_now = (seg == '0) ? eng_dout : ks_reg;

  for (genvar g = 0; g < NSEG; g++) begin : g_word
    assign ks_words[g] = ks_now[BLK_W-1-g*SEG_W -: SEG_W];
  end

  assign seg_res = in_blk[SEG_W-1:0] ^ ks_words[seg];

  always_comb begin
    case (mode)
      MD_ECB:         eng_din = in_blk;
      MD_CBC, MD_MAC: eng_din = in_blk ^ chain;
      default:        eng_din = chain;
    endcase
  end

  always_comb begin
    case (mode)
      MD_CFB:  fb_next = {ct_prev, seg_res};
      MD_OFB:  fb_next = ks_now;
      MD_CTR:  fb_next = {chain[BLK_W-1:CTR_W], chain[CTR_W-1:0] + 1'b1};
      default: fb_next = chain;
    endcase
  end
endmodule

// File: rtl/bcs_top.sv
`timescale 1ns/1ps
module bcs_top
  import bcs_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int SEG_W = 32,
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [1:0]       cmd_code,
  input  logic [2:0]       cmd_mode,
  output logic             ready,
  input  logic             din_we,
  input  logic [7:0]       din,
  output logic             in_req,
  input  logic             dout_re,
  output logic [7:0]       dout,
  output logic             out_req,
  output logic             irq,
  output logic             eng_start,
  output logic [BLK_W-1:0] eng_din,
  output logic [BLK_W-1:0] eng_key,
  input  logic             eng_done,
  input  logic [BLK_W-1:0] eng_dout
);
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int SEG_BYTES = SEG_W / 8;
  localparam int NSEG      = BLK_W / SEG_W;
  localparam int SIW       = $clog2(NSEG);
  localparam int CNT_W     = $clog2(BLK_BYTES);
  localparam int CT_W      = BLK_W - SEG_W;
  localparam logic [CNT_W-1:0] LAST_BLK = CNT_W'(BLK_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_SEG = CNT_W'(SEG_BYTES - 1);
  localparam logic [SIW-1:0]   SEG_TOP  = SIW'(NSEG - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SIW-1:0]   seg_q, seg_d;
  logic [2:0]       mode_q, mode_d;
  logic [BLK_W-1:0] key_q, chain_q, chain_d, ks_q;
  logic [CT_W-1:0]  ct_q, ct_d;
  logic             key_en, chain_en, ks_en, ct_en;
  logic             in_req_d, out_req_d, irq_d, go_d, go_q;
  logic             in_req_q, out_req_q, irq_q;
  logic             out_ld;

  logic [BLK_W-1:0] in_q, out_q, out_ld_val, shift_nxt;
  logic [SEG_W-1:0] seg_res;
  logic [BLK_W-1:0] fb_next;
  logic             stream, need_eng, cmd_hit, din_take, dout_take;
  logic [CNT_W-1:0] last_cnt;

  assign stream   = is_stream(mode_q);
  assign need_eng = !stream || (seg_q == '0);
  assign last_cnt = stream ? LAST_SEG : LAST_BLK;

  // a command that takes effect: loads always, start only when idle
  assign cmd_hit  = cmd_we && ((cmd_code == CMD_KEY) || (cmd_code == CMD_IV) ||
                               ((cmd_code == CMD_GO) && (st_q == ST_IDLE)));
  assign din_take = din_we && !cmd_hit &&
                    ((st_q == ST_LKEY) || (st_q == ST_LIV) || (st_q == ST_FILL));
  assign dout_take = dout_re && !cmd_hit && (st_q == ST_EMIT);

  assign shift_nxt  = {in_q[BLK_W-9:0], din};
  assign out_ld_val = stream ? {seg_res, {CT_W{1'b0}}} : eng_dout;

  bcs_shift8 #(.W(BLK_W)) u_in (
    .clk(clk), .rst_n(rst_s_n), .ld(1'b0), .ld_val({BLK_W{1'b0}}),
    .sh(din_take), .sh_in(din), .q(in_q)
  );

  bcs_shift8 #(.W(BLK_W)) u_out (
    .clk(clk), .rst_n(rst_s_n), .ld(out_ld), .ld_val(out_ld_val),
    .sh(dout_take), .sh_in(8'h00), .q(out_q)
  );

  bcs_mode_path #(.BLK_W(BLK_W), .SEG_W(SEG_W), .CTR_W(CTR_W)) u_path (
    .mode(mode_q), .in_blk(in_q), .chain(chain_q), .ks_reg(ks_q),
    .eng_dout(eng_dout), .seg(seg_q), .ct_prev(ct_q),
    .eng_din(eng_din), .seg_res(seg_res), .fb_next(fb_next)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    seg_d     = seg_q;
    mode_d    = mode_q;
    chain_d   = chain_q;
    ct_d      = {ct_q[CT_W-SEG_W-1:0], seg_res};
    key_en    = 1'b0;
    chain_en  = 1'b0;
    ks_en     = 1'b0;
    ct_en     = 1'b0;
    in_req_d  = 1'b0;
    out_req_d = 1'b0;
    irq_d     = 1'b0;
    go_d      = 1'b0;
    out_ld    = 1'b0;
    if (cmd_hit && (cmd_code == CMD_KEY)) begin
      st_d  = ST_LKEY;
      cnt_d = '0;
    end else if (cmd_hit && (cmd_code == CMD_IV)) begin
      st_d   = ST_LIV;
      cnt_d  = '0;
      mode_d = cmd_mode;
    end else if (cmd_hit) begin
      st_d     = ST_FILL;
      cnt_d    = '0;
      seg_d    = '0;
      mode_d   = cmd_mode;
      in_req_d = 1'b1;
    end else begin
      case (st_q)
        ST_LKEY, ST_LIV: begin
          if (din_take) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BLK) begin
              st_d = ST_IDLE;
              if (st_q == ST_LKEY) key_en = 1'b1;
              else begin
                chain_en = 1'b1;
                chain_d  = shift_nxt;
              end
            end
          end
        end
        ST_FILL: begin
          if (din_take) begin
            if (cnt_q == last_cnt) begin
              cnt_d = '0;
              st_d  = ST_RUN;
              go_d  = need_eng;
            end else begin
              cnt_d    = cnt_q + 1'b1;
              in_req_d = 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (!need_eng || eng_done) begin
            st_d      = ST_EMIT;
            out_ld    = 1'b1;
            out_req_d = 1'b1;
            if (!stream) begin
              chain_en = (mode_q == MD_CBC) || (mode_q == MD_MAC);
              chain_d  = eng_dout;
            end else begin
              ks_en = (seg_q == '0);
              ct_en = 1'b1;
              if (seg_q == SEG_TOP) begin
                chain_en = 1'b1;
                chain_d  = fb_next;
              end
            end
          end
        end
        ST_EMIT: begin
          if (dout_take) begin
            if (cnt_q == last_cnt) begin
              cnt_d = '0;
              if (stream && (seg_q != SEG_TOP)) begin
                seg_d    = seg_q + 1'b1;
                st_d     = ST_FILL;
                in_req_d = 1'b1;
              end else begin
                st_d  = ST_IDLE;
                irq_d = 1'b1;
              end
            end else begin
              cnt_d     = cnt_q + 1'b1;
              out_req_d = 1'b1;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      seg_q     <= '0;
      mode_q    <= MD_ECB;
      in_req_q  <= 1'b0;
      out_req_q <= 1'b0;
      irq_q     <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      seg_q     <= seg_d;
      mode_q    <= mode_d;
      in_req_q  <= in_req_d;
      out_req_q <= out_req_d;
      irq_q     <= irq_d;
      go_q      <= go_d;
    end
  end

  // wide registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      key_q   <= '0;
      chain_q <= '0;
      ks_q    <= '0;
      ct_q    <= '0;
    end else begin
      if (key_en)   key_q   <= shift_nxt;
      if (chain_en) chain_q <= chain_d;
      if (ks_en)    ks_q    <= eng_dout;
      if (ct_en)    ct_q    <= ct_d;
    end
  end

  assign ready     = (st_q == ST_IDLE);
  assign in_req    = in_req_q;
  assign out_req   = out_req_q;
  assign irq       = irq_q;
  assign eng_start = go_q;
  assign eng_key   = key_q;
  assign dout      = out_q[BLK_W-1 -: 8];

  AST_KEY_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q != ST_LKEY) |=> $stable(key_q)); // R2
  AST_DIN_HELD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_RUN && need_eng && !eng_done && !cmd_hit) |=> $stable(eng_din)); // R13
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    eng_start |=> !eng_start); // R13
  AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> ready); // R11
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |=> !irq); // R11
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(in_req && out_req)); // R12
  AST_BUSY_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_we && cmd_code == CMD_GO && !ready) |=> $stable(mode_q)); // R9
endmodule

// File: tb/tb_bcs_top.sv
`timescale 1ns/1ps
module tb_bcs_top;
  logic         clk, rst_n;
  logic         cmd_we, din_we, dout_re, eng_done;
  logic [1:0]   cmd_code;
  logic [2:0]   cmd_mode;
  logic [7:0]   din, dout;
  logic         ready, in_req, out_req, irq, eng_start;
  logic [127:0] eng_din, eng_key, eng_dout;

  bcs_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_mode(cmd_mode),
    .ready(ready), .din_we(din_we), .din(din), .in_req(in_req), .dout_re(dout_re),
    .dout(dout), .out_req(out_req), .irq(irq), .eng_start(eng_start), .eng_din(eng_din),
    .eng_key(eng_key), .eng_done(eng_done), .eng_dout(eng_dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int in_seen = 0, out_seen = 0, irq_seen = 0, go_seen = 0;
  int in_used = 0, out_used = 0;
  logic [127:0] m_key = '0, m_chain = '0;

  // engine stand-in with random latency
  function automatic logic [127:0] ef(input logic [127:0] x, input logic [127:0] k);
    return {x[118:0], x[127:119]} ^ k ^ {x[63:0], ~x[127:64]};
  endfunction

  logic [127:0] eng_hold;
  int eng_wait = 0;
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      eng_hold <= ef(eng_din, eng_key);
      eng_wait <= 1 + int'($urandom % 4);
    end else if (eng_wait > 0) begin
      eng_wait <= eng_wait - 1;
      if (eng_wait == 1) begin
        eng_done <= 1'b1;
        eng_dout <= eng_hold;
      end
    end
  end

  always @(negedge clk) begin
    if (in_req)    in_seen++;
    if (out_req)   out_seen++;
    if (irq)       irq_seen++;
    if (eng_start) go_seen++;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic resync();
    tick();
    in_used  = in_seen;
    out_used = out_seen;
  endtask

  task automatic send_cmd(input logic [1:0] c, input logic [2:0] m);
    cmd_we = 1'b1; cmd_code = c; cmd_mode = m;
    tick();
    cmd_we = 1'b0; cmd_code = 2'd0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    din = b; din_we = 1'b1;
    tick();
    din_we = 1'b0;
  endtask

  task automatic load16(input logic [1:0] c, input logic [2:0] m, input logic [127:0] v);
    send_cmd(c, m);
    for (int i = 0; i < 16; i++) put_byte(v[127-8*i -: 8]);
  endtask

  task automatic load_key(input logic [127:0] k);
    load16(2'd1, 3'd0, k);
    m_key = k;
    chk(eng_key == k, "R2 key visible", eng_key, k);
  endtask

  task automatic load_iv(input logic [127:0] v, input logic [2:0] m);
    load16(2'd2, m, v);
    m_chain = v;
    chk(ready, "R4 ready after IV load", {127'd0, ready}, 128'd1);
  endtask

  function automatic logic [127:0] model(input logic [127:0] d, input logic [2:0] md);
    logic [127:0] ks, r;
    case (md)
      3'd0: r = ef(d, m_key);
      3'd1, 3'd5: begin r = ef(d ^ m_chain, m_key); m_chain = r; end
      3'd2: begin ks = ef(m_chain, m_key); r = d ^ ks; m_chain = r; end
      3'd3: begin ks = ef(m_chain, m_key); r = d ^ ks; m_chain = ks; end
      default: begin
        ks = ef(m_chain, m_key); r = d ^ ks;
        m_chain[31:0] = m_chain[31:0] + 32'd1;
      end
    endcase
    return r;
  endfunction

  task automatic wait_in();
    while (in_seen <= in_used) tick();
    in_used++;
  endtask

  task automatic wait_out();
    while (out_seen <= out_used) tick();
    out_used++;
  endtask

  // busy_go: issue an ignored start in the middle of collection
  task automatic blk(input logic [127:0] d, input logic [2:0] md, input string tag, input bit busy_go);
    logic [127:0] exp, got;
    int i0, o0, q0, g0, nseg, bps;
    exp = model(d, md);
    got = '0;
    i0 = in_seen; o0 = out_seen; q0 = irq_seen; g0 = go_seen;
    nseg = (md == 3'd2 || md == 3'd3 || md == 3'd4) ? 4 : 1;
    bps = 16 / nseg;
    send_cmd(2'd3, md);
    for (int s = 0; s < nseg; s++) begin
      for (int b = 0; b < bps; b++) begin
        wait_in();
        if (busy_go && s == 0 && b == bps / 2) begin
          send_cmd(2'd3, 3'd4);
          chk(!ready, "R9 busy while collecting", {127'd0, ready}, 128'd0);
        end
        put_byte(d[127-8*(s*bps+b) -: 8]);
      end
      for (int b = 0; b < bps; b++) begin
        wait_out();
        got = {got[119:0], dout};
        dout_re = 1'b1;
        tick();
        dout_re = 1'b0;
      end
    end
    chk(got == exp, tag, got, exp);
    chk(irq_seen - q0 == 1 && ready, "R11 one irq with ready",
        128'(irq_seen - q0), 128'd1);
    chk(in_seen - i0 == 16 && out_seen - o0 == 16, "R12 request counts",
        {64'(in_seen - i0), 64'(out_seen - o0)}, {64'd16, 64'd16});
    chk(go_seen - g0 == 1, "R13 one engine start", 128'(go_seen - g0), 128'd1);
  endtask

  initial begin
    cmd_we = 0; cmd_code = 0; cmd_mode = 0; din_we = 0; din = 0; dout_re = 0;
    rst_n = 1'b0;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk(eng_key == '0, "R1 key cleared", eng_key, '0);
    chk(ready && !in_req && !out_req && !irq && !eng_start, "R1 idle outputs",
        {123'd0, ready, in_req, out_req, irq, eng_start}, {123'd0, 5'b10000});
    // chaining register is zero: CBC with zero chain equals plain encryption
    load_key(128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0);
    begin
      logic [127:0] z;
      z = 128'h00112233_44556677_8899aabb_ccddeeff;
      blk(z, 3'd1, "R1 chain zero after reset", 0);
    end

    blk(128'h01234567_89abcdef_fedcba98_76543210, 3'd0, "R3 ECB", 0);
    blk(128'hdeadbeef_00000000_ffffffff_12345678, 3'd0, "R3 ECB second", 0);

    load_iv(128'ha5a5a5a5_5a5a5a5a_3c3c3c3c_c3c3c3c3, 3'd1);
    blk(128'h11111111_22222222_33333333_44444444, 3'd1, "R4 CBC first", 0);
    blk(128'h55555555_66666666_77777777_88888888, 3'd1, "R4 CBC chained", 0);

    load_iv(128'h13579bdf_2468ace0_0f0f0f0f_f0f0f0f0, 3'd2);
    blk(128'hcafebabe_0badf00d_8badf00d_feedface, 3'd2, "R5 CFB first", 0);
    blk(128'h00000000_00000000_00000000_00000001, 3'd2, "R5 CFB chained", 0);

    load_iv(128'h31415926_53589793_23846264_33832795, 3'd3);
    blk(128'h0, 3'd3, "R6 OFB zero data", 0);
    blk(128'hffffffff_ffffffff_ffffffff_ffffffff, 3'd3, "R6 OFB chained", 0);

    load_iv(128'h00000000_00000007_ffffffff_ffffffff, 3'd4);
    blk(128'h89abcdef_01234567_76543210_fedcba98, 3'd4, "R7 CTR at wrap", 0);
    blk(128'h89abcdef_01234567_76543210_fedcba98, 3'd4, "R7 CTR after wrap", 0);

    load_iv(128'h27182818_28459045_23536028_74713526, 3'd5);
    blk(128'h10203040_50607080_90a0b0c0_d0e0f000, 3'd5, "R8 MAC first", 0);
    blk(128'h0a0b0c0d_0e0f1011_12131415_16171819, 3'd5, "R8 MAC second", 0);
    blk(128'h80000000_00000000_00000000_00000000, 3'd1, "R8 mode switch at start", 0);

    // R9: stray byte while idle, then a start while collecting
    put_byte(8'h99);
    blk(128'h0badcafe_0badcafe_0badcafe_0badcafe, 3'd0, "R9 stray byte and busy start ignored", 1);

    // R10: IV command with a simultaneous data byte aborts a block
    begin
      int q0;
      q0 = irq_seen;
      send_cmd(2'd3, 3'd0);
      for (int i = 0; i < 5; i++) begin wait_in(); put_byte(8'h40 + 8'(i)); end
      din = 8'hee; din_we = 1'b1;
      send_cmd(2'd2, 3'd1);
      din_we = 1'b0;
      for (int i = 0; i < 16; i++) put_byte(8'h70 + 8'(i));
      m_chain = 128'h70717273_74757677_78797a7b_7c7d7e7f;
      chk(irq_seen == q0 && ready, "R10 abort without irq", 128'(irq_seen - q0), 128'd0);
      resync();
      blk(128'h00000000_11111111_22222222_33333333, 3'd1, "R10 IV after abort", 0);
      q0 = irq_seen;
      send_cmd(2'd3, 3'd0);
      for (int i = 0; i < 3; i++) begin wait_in(); put_byte(8'h11); end
      load_key(128'hfedcba98_76543210_01234567_89abcdef);
      chk(irq_seen == q0, "R10 key abort without irq", 128'(irq_seen - q0), 128'd0);
      resync();
      blk(128'h5a5a5a5a_a5a5a5a5_5a5a5a5a_a5a5a5a5, 3'd0, "R10 ECB after key abort", 0);
    end

    // random mix of modes and data
    for (int n = 0; n < 10; n++) begin
      logic [127:0] d;
      logic [2:0] md;
      d = {$urandom, $urandom, $urandom, $urandom};
      md = 3'($urandom % 6);
      if ($urandom % 4 == 0)
        load_iv({$urandom, $urandom, $urandom, $urandom}, md);
      blk(d, md, $sformatf("R3 R4 R5 R6 R7 R8 random mode %0d", md), 0);
    end
    chk(eng_key == m_key, "R2 key kept across blocks", eng_key, m_key);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule